// File: doc/BRIEF.md
# Stepper Driver Supervisory Sequencer

This block decides, every clock, whether the two power bridges of a bipolar stepper driver may conduct and whether a step request may reach the indexer. It combines three control inputs with three protection flags. The control inputs are an active-low indexer reset, an active-low enable and an active-low sleep. The protection flags come from analog sensing already turned into clocked digital levels: a per-FET current limit, an overtemperature flag and a supply undervoltage flag. It drives four outputs: a bridge enable, an active-high indexer reset, a one-cycle qualified step pulse and an active-low fault line.

Two kinds of fault are handled. Overcurrent is qualified by a clock count. Once qualified, it latches and holds the bridges off until the indexer reset is applied, the supply dips or the block reset is asserted. Overtemperature is not latched: the bridges come back by themselves as soon as the flag drops. After sleep is left, a hold-off timer keeps the bridges off and refuses step requests. This gives the analog circuits time to settle before the motor is driven. All inputs are expected to be synchronous to `clk`.

Top module: `mdrv_supervisor`

## Requirements
- R1: When the synchronous reset `rst` is released, the overcurrent latch and the wake timer are clear. With the controls in their run state, `bridge_en` is 1 and `fault_n` is 1 in the first cycle after `rst` falls.
- R2: While `sleep_n` is 1 and `reset_n` is 0, `idx_rst` is 1, `bridge_en` is 0 and `step_go` stays 0.
- R3: While `enable_n` is 1, `bridge_en` is 0 and `step_go` stays 0. With `enable_n` at 0 and no other blocking condition, `bridge_en` is 1.
- R4: `step_go` is 1 for exactly one cycle: the first cycle in which `step_in` is 1 after a cycle in which it was 0. It fires only when the bridges are not blocked by reset, enable, sleep, undervoltage or the wake timer. Faults do not block it.
- R5: While `sleep_n` is 0, `bridge_en` and `step_go` are 0 and `reset_n`, `enable_n` and `oc_limit` have no effect. `idx_rst` is 0 unless `uv_flag` or `rst` is 1, and the overcurrent qualifier count is frozen.
- R6: After `sleep_n` returns to 1, `bridge_en` and `step_go` stay 0 for exactly `WAKE_CYCLES` clock cycles.
- R7: The overcurrent latch sets after `oc_limit` has been sampled 1 on `OC_QUAL` consecutive active clock edges. A single sample of 0 restarts the count.
- R8: Once set, the overcurrent latch holds `bridge_en` at 0 and `fault_n` at 0. It is cleared only by `rst`, by `uv_flag`, or by `reset_n` at 0 while `sleep_n` is 1.
- R9: While `ot_flag` is 1, `bridge_en` is 0 and `fault_n` is 0. Both recover in the same cycle the flag returns to 0, with no latching.
- R10: While `uv_flag` is 1, `bridge_en` and `step_go` are 0, `idx_rst` is 1, and the overcurrent latch and its count are cleared.
- R11: `fault_n` is 0 exactly when the overcurrent latch is set or `ot_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on / supply restore) |
| reset_n | input | 1 | Active-low indexer reset and overcurrent clear |
| enable_n | input | 1 | Active-low bridge and step enable |
| sleep_n | input | 1 | Active-low sleep request |
| step_in | input | 1 | Raw step request level |
| oc_limit | input | 1 | Per-FET current limit active |
| ot_flag | input | 1 | Die overtemperature |
| uv_flag | input | 1 | Motor supply undervoltage |
| bridge_en | output | 1 | Both bridges may conduct |
| idx_rst | output | 1 | Force the indexer to its home state |
| step_go | output | 1 | One-cycle qualified step pulse |
| fault_n | output | 1 | Active-low fault indication |

## Verification
A wrong overcurrent latch shows on `fault_n` and `bridge_en` in the cycle after the qualifying edge. That is one edge early or late if the qualifier count is off, or never if a clear path is missing. A wrong wake counter moves the first cycle with `bridge_en` high after sleep. A stale step-edge register shows up as a missing or doubled `step_go`. A reference model that tracks each of these states is compared against all four outputs on every cycle, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/mdrv_sup_pkg.sv
package mdrv_sup_pkg;

    // Conditions that must all hold for the bridges to run.
    typedef struct packed {
        logic supply_ok;   // no undervoltage
        logic awake;       // out of sleep and wake timer expired
        logic released;    // indexer reset not applied
        logic enabled;     // enable input active
    } gate_t;

    function automatic logic gate_open(gate_t g);
        return g.supply_ok & g.awake & g.released & g.enabled;
    endfunction

    function automatic logic drive_allowed(gate_t g, logic oc_latched, logic over_temp);
        return gate_open(g) & ~oc_latched & ~over_temp;
    endfunction

endpackage

// File: rtl/mdrv_wake_timer.sv
module mdrv_wake_timer #(
    parameter int WAKE_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_n,
    output logic ready
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (!sleep_n)
            remain <= LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign ready = sleep_n && (remain == '0);

    // R6: the cycle after sleep is held, the timer is not ready
    p_wake_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> !ready);
endmodule

// File: rtl/mdrv_oc_latch.sv
module mdrv_oc_latch #(
    parameter int OC_QUAL = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic freeze,
    input  logic clear,
    input  logic limit,
    output logic latched
);
    localparam int QW = $clog2(OC_QUAL + 1);
    localparam logic [QW-1:0] LAST = QW'(OC_QUAL - 1);

    logic [QW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            latched <= 1'b0;
        end else if (freeze) begin
            run_len <= run_len;
        end else if (clear) begin
            run_len <= '0;
            latched <= 1'b0;
        end else if (!latched) begin
            if (!limit)
                run_len <= '0;
            else if (run_len == LAST) begin
                run_len <= '0;
                latched <= 1'b1;
            end else
                run_len <= run_len + 1'b1;
        end
    end

    // R8: without a clear the latch does not drop
    p_latch_holds_r8: assert property (@(posedge clk) disable iff (rst)
        latched && !clear |=> latched);
    // R7: the latch only rises on an edge where the limit was sampled high
    p_latch_needs_limit_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(latched) |-> $past(limit) && !$past(freeze));
endmodule

// File: rtl/mdrv_step_edge.sv
module mdrv_step_edge (
    input  logic clk,
    input  logic rst,
    input  logic step_in,
    input  logic allow,
    output logic step_go
);
    logic step_prev;

    always_ff @(posedge clk) begin
        if (rst)
            step_prev <= 1'b0;
        else
            step_prev <= step_in;
    end

    assign step_go = step_in && !step_prev && allow;

    // R4: a qualified step never lasts two cycles
    p_step_single_r4: assert property (@(posedge clk) disable iff (rst)
        step_go |=> !step_go);
endmodule

// File: rtl/mdrv_supervisor.sv
module mdrv_supervisor
    import mdrv_sup_pkg::*;
#(
    parameter int WAKE_CYCLES = 200000,
    parameter int OC_QUAL     = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic reset_n,
    input  logic enable_n,
    input  logic sleep_n,
    input  logic step_in,
    input  logic oc_limit,
    input  logic ot_flag,
    input  logic uv_flag,
    output logic bridge_en,
    output logic idx_rst,
    output logic step_go,
    output logic fault_n
);
    logic  awake;
    logic  oc_latched;
    logic  oc_clear;
    gate_t gate;

    mdrv_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk     (clk),
        .rst     (rst),
        .sleep_n (sleep_n),
        .ready   (awake)
    );

    assign oc_clear = uv_flag || !reset_n;

    mdrv_oc_latch #(.OC_QUAL(OC_QUAL)) u_oc (
        .clk     (clk),
        .rst     (rst),
        .freeze  (!sleep_n && !uv_flag),
        .clear   (oc_clear),
        .limit   (oc_limit),
        .latched (oc_latched)
    );

    always_comb begin
        gate.supply_ok = !uv_flag;
        gate.awake     = awake;
        gate.released  = reset_n;
        gate.enabled   = !enable_n;
    end

    mdrv_step_edge u_step (
        .clk     (clk),
        .rst     (rst),
        .step_in (step_in),
        .allow   (gate_open(gate)),
        .step_go (step_go)
    );

    assign bridge_en = drive_allowed(gate, oc_latched, ot_flag);
    assign idx_rst   = rst || uv_flag || (sleep_n && !reset_n);
    assign fault_n   = !(oc_latched || ot_flag);

    // R5: sleep keeps the bridges off and masks the indexer reset
    p_sleep_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |-> !bridge_en && !step_go && (uv_flag || !idx_rst));
    // R9: overtemperature always shows as a fault with the bridges off
    p_ot_fault_r9: assert property (@(posedge clk) disable iff (rst)
        ot_flag |-> !fault_n && !bridge_en);
    // R10: undervoltage resets the indexer and clears the latch next cycle
    p_uv_reset_r10: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> idx_rst && !bridge_en && !step_go);
    p_uv_clears_r10: assert property (@(posedge clk) disable iff (rst)
        uv_flag && !ot_flag |=> fault_n || ot_flag);
endmodule

// File: tb/tb_mdrv_supervisor.sv
`timescale 1ns/1ps
module tb_mdrv_supervisor;
    localparam int W = 40;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reset_n = 1'b1, enable_n = 1'b0, sleep_n = 1'b1, step_in = 1'b0;
    logic oc_limit = 1'b0, ot_flag = 1'b0, uv_flag = 1'b0;
    logic bridge_en, idx_rst, step_go, fault_n;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 1'b0;
    string req = "R1";

    // reference model state
    int  m_wake = 0;
    int  m_run  = 0;
    bit  m_lat  = 0;
    bit  m_prev = 0;

    always #2.5 clk = ~clk;

    mdrv_supervisor #(.WAKE_CYCLES(W), .OC_QUAL(Q)) dut (
        .clk(clk), .rst(rst), .reset_n(reset_n), .enable_n(enable_n),
        .sleep_n(sleep_n), .step_in(step_in), .oc_limit(oc_limit),
        .ot_flag(ot_flag), .uv_flag(uv_flag), .bridge_en(bridge_en),
        .idx_rst(idx_rst), .step_go(step_go), .fault_n(fault_n)
    );

    task automatic check(string r, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", r, what, act, exp, $time);
        end
    endtask

    // behavioural model advance on each edge (inputs settle 1 ns after the edge)
    always @(posedge clk) begin
        if (rst) begin
            m_wake = 0; m_run = 0; m_lat = 0; m_prev = 0;
        end else begin
            m_prev = step_in;
            if (!sleep_n) m_wake = W;
            else if (m_wake > 0) m_wake = m_wake - 1;
            if (!sleep_n && !uv_flag) begin
            end else if (uv_flag || !reset_n) begin
                m_run = 0; m_lat = 0;
            end else if (!m_lat) begin
                if (!oc_limit) m_run = 0;
                else begin
                    m_run = m_run + 1;
                    if (m_run == Q) begin m_run = 0; m_lat = 1; end
                end
            end
        end
    end

    // compare every output on every cycle, away from the active edge
    always @(negedge clk) begin
        bit open, e_br, e_st, e_ir, e_f;
        if (!done) begin
            open = sleep_n && (m_wake == 0) && !uv_flag && reset_n && !enable_n;
            e_br = open && !m_lat && !ot_flag;
            e_st = step_in && !m_prev && open;
            e_ir = rst || uv_flag || (sleep_n && !reset_n);
            e_f  = !(m_lat || ot_flag);
            check(req, bridge_en, e_br, "bridge_en");
            check(req, step_go, e_st, "step_go");
            check(req, idx_rst, e_ir, "idx_rst");
            check("R11", fault_n, e_f, "fault_n");
            if (step_go) pulses++;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic neg;
        @(negedge clk);
    endtask

    task automatic step_train(int n);
        for (int i = 0; i < n; i++) begin
            step_in = 1'b1; tick(3);
            step_in = 1'b0; tick(2);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        $display("FAIL watchdog expired");
        fails++; checks++;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int p0;
        tick(3);
        rst = 1'b0;
        neg;
        // R1: run state immediately after reset release, no wake delay
        check("R1", bridge_en, 1'b1, "bridge after rst");
        check("R1", fault_n, 1'b1, "fault after rst");
        tick();

        req = "R4"; p0 = pulses;
        step_train(5);
        check("R4", pulses - p0 == 5, 1'b1, "five steps five pulses");

        req = "R3"; enable_n = 1'b1; p0 = pulses;
        step_train(3);
        check("R3", pulses == p0, 1'b1, "no steps while disabled");
        neg; check("R3", bridge_en, 1'b0, "bridge disabled");
        tick(); enable_n = 1'b0; tick();

        req = "R2"; reset_n = 1'b0; p0 = pulses;
        step_train(2);
        neg; check("R2", idx_rst, 1'b1, "indexer reset");
        check("R2", pulses == p0, 1'b1, "no steps in reset");
        tick(); reset_n = 1'b1; tick();

        req = "R5"; sleep_n = 1'b0; reset_n = 1'b0; oc_limit = 1'b1; p0 = pulses;
        step_train(4);
        neg; check("R5", idx_rst, 1'b0, "reset ignored asleep");
        check("R5", pulses == p0, 1'b1, "no steps asleep");
        tick(); oc_limit = 1'b0; reset_n = 1'b1;

        req = "R6"; sleep_n = 1'b1;
        tick(W - 1);
        neg; check("R6", bridge_en, 1'b0, "still held at last wake cycle");
        tick();
        neg; check("R6", bridge_en, 1'b1, "released after wake");
        tick();

        req = "R7"; oc_limit = 1'b1; tick(Q - 1); oc_limit = 1'b0; tick();
        neg; check("R7", fault_n, 1'b1, "short burst not latched");
        oc_limit = 1'b1; tick(Q - 1);
        neg; check("R7", fault_n, 1'b1, "not latched one early");
        tick();
        neg; check("R7", fault_n, 1'b0, "latched on qualifying edge");
        oc_limit = 1'b0;

        req = "R8"; tick(10);
        neg; check("R8", bridge_en, 1'b0, "latch holds bridge off");
        sleep_n = 1'b0; reset_n = 1'b0; tick(3);
        neg; check("R8", fault_n, 1'b0, "reset in sleep does not clear");
        reset_n = 1'b1; sleep_n = 1'b1; tick(W + 2);
        reset_n = 1'b0; tick(); reset_n = 1'b1; tick();
        neg; check("R8", fault_n, 1'b1, "cleared by indexer reset");

        req = "R9"; ot_flag = 1'b1; step_train(2); tick();
        neg; check("R9", bridge_en, 1'b0, "over temp off");
        ot_flag = 1'b0; tick();
        neg; check("R9", bridge_en, 1'b1, "auto resume");

        req = "R10"; oc_limit = 1'b1; tick(Q); oc_limit = 1'b0;
        uv_flag = 1'b1; p0 = pulses; step_train(2);
        neg; check("R10", idx_rst, 1'b1, "uv indexer reset");
        check("R10", pulses == p0, 1'b1, "no steps in uv");
        uv_flag = 1'b0; tick();
        neg; check("R10", fault_n, 1'b1, "uv cleared latch");

        req = "R8"; oc_limit = 1'b1; tick(Q); oc_limit = 1'b0;
        rst = 1'b1; tick(2); rst = 1'b0; tick();
        neg; check("R8", fault_n, 1'b1, "rst clears latch");
        tick(5);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule